// File: doc/BRIEF.md
# Burst DMA Bus Master Interface

This block is the bus-master end of a burst DMA engine. A local controller gives it one command: the direction, a start address, a word count and a sampling-mode bit. The block then asks for the system bus with an active-low request and waits for the arbiter's active-low grant. It drives one address cycle on the shared address/data lines and then moves one bus-wide word for each cycle in which the target signals ready. Reads deliver the captured word to the payload side. Writes take the word offered by the payload side and advance it on acceptance.

An active-low abort during a data cycle cancels that word. The request is dropped for at least one cycle and raised again once the grant has gone high. The burst then restarts with a fresh address cycle at the word that was cancelled. An active-low bus error halts everything at once. It also sets a sticky error bit in a status word, and that bit raises an interrupt unless masked. The sampling-mode bit chooses whether ready and abort act in the cycle they are seen or one cycle later through a register stage.

Top module: `burst_dma_master`

## Requirements
- R1: After reset: req_n=1, dir_rd=1, ad_oe=0, addr_strobe=0, word_ack=0, done=0, status=0, irq=0.
- R2: A command is taken in the idle state when cmd_valid=1. From the next cycle dir_rd equals cmd_read (1 = read, 0 = write). A command with cmd_count=0 gives done=1 in the next cycle, and req_n stays 1.
- R3: req_n only goes low after a cycle in which grant_n was 1. The grant is honoured no earlier than one clock after req_n went low. After that comes exactly one cycle with addr_strobe=1, ad_oe=1 and ad_out equal to the current word address.
- R4: Each accepted word gives word_ack=1, adds BUS_W/8 to the address and takes one from the remaining count. On a read, rd_data is the bus word captured with the ready. On a write, ad_oe=1 and ad_out=wr_data during the data phase. Exactly cmd_count words are acknowledged.
- R5: In the data phase req_n is 0 while more than one word remains and 1 once the remaining count is one. done=1 for exactly one cycle, the cycle after the final word_ack.
- R6: With cmd_early=0, ready_n=0 in data cycle k gives word_ack in cycle k+1, and rd_data is the bus value from cycle k. With cmd_early=1, word_ack is given in cycle k itself, and rd_data is the current bus value.
- R7: An abort_n=0 in a data cycle is acted on in the same cycle with cmd_early=1, or in the next cycle with cmd_early=0. That cycle gives no word_ack even if ready is low. The next cycle has req_n=1. A new address cycle follows, carrying the address of the cancelled word, and the remaining words complete.
- R8: buserr_n=0 in any cycle makes the next cycle show req_n=1 and ad_oe=0, and the block stays idle with no new request.
- R9: buserr_n=0 sets status bit 25. The bit is cleared only by err_clr=1 and otherwise stays set. irq=1 exactly when status bit 25 is 1 and irq_mask=0.
- R10: After a bus error, a new command runs a complete burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe from the local controller |
| cmd_read | input | 1 | 1 = read burst, 0 = write burst |
| cmd_early | input | 1 | 1 = act on ready/abort in the cycle seen |
| cmd_addr | input | BUS_W | Start word address |
| cmd_count | input | CNT_W | Number of words |
| req_n | output | 1 | Bus request, active low |
| grant_n | input | 1 | Bus grant, active low |
| ready_n | input | 1 | Target ready, active low |
| abort_n | input | 1 | Cycle abort, active low |
| buserr_n | input | 1 | System bus error, active low |
| dir_rd | output | 1 | Transfer direction, 1 = read |
| addr_strobe | output | 1 | Bus carries an address this cycle |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_out | output | BUS_W | Address or write word driven on the shared lines |
| ad_in | input | BUS_W | Value seen on the shared lines |
| wr_data | input | BUS_W | Current write word from the payload side |
| rd_data | output | BUS_W | Read word, valid with word_ack on a read |
| word_ack | output | 1 | One word accepted this cycle |
| done | output | 1 | One-cycle burst completion pulse |
| irq_mask | input | 1 | 1 = suppress the error interrupt |
| err_clr | input | 1 | Write-one-to-clear of the error bit |
| status | output | 32 | Status word, bit 25 = bus error |
| irq | output | 1 | Error interrupt |

## Verification
The main data path is driven by a set of bursts that vary direction, sampling mode, length, the ready pattern and the position of an abort. Ready held low in every cycle exposes the one-cycle latency gap between the two sampling modes. Sparse and alternating ready patterns show whether gaps stall the count without losing or repeating words, and whether read data stays paired with its own ready. Aborts placed before the last word, with ready also low, show that abort wins over ready, that the request backs off, and that the resumed address is the cancelled word. Single-word and zero-length commands test the moment the request is released. A bus error injected mid-burst is followed by mask and clear operations and a fresh command.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_REQ,
        ST_ADDR,
        ST_DATA
    } bdm_state_e;

endpackage

// File: rtl/bdm_sampler.sv
module bdm_sampler #(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             early,
    input  logic             in_data,
    input  logic             ready_n,
    input  logic             abort_n,
    input  logic [BUS_W-1:0] ad_in,
    output logic             rdy,
    output logic             abt,
    output logic [BUS_W-1:0] data
);

    typedef struct packed {
        logic             vld;
        logic             rdy;
        logic             abt;
        logic [BUS_W-1:0] data;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.vld  = in_data;
        smp_d.rdy  = ~ready_n;
        smp_d.abt  = ~abort_n;
        smp_d.data = ad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    always_comb begin
        if (early) begin
            rdy  = ~ready_n;
            abt  = ~abort_n;
            data = ad_in;
        end else begin
            rdy  = smp_q.vld & smp_q.rdy;
            abt  = smp_q.vld & smp_q.abt;
            data = smp_q.data;
        end
    end

    // R6: in the late mode a ready seen now was on the pin one clock ago
    a_r6_late_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!early && rdy) |-> $past(!ready_n && in_data));

endmodule

// File: rtl/bdm_walker.sv
module bdm_walker #(
    parameter int BUS_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] load_addr,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             step,
    output logic [BUS_W-1:0] addr,
    output logic [CNT_W-1:0] remain,
    output logic             last
);

    localparam int STEP = BUS_W / 8;
    localparam logic [BUS_W-1:0] STEP_V = BUS_W'(STEP);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        logic [BUS_W-1:0] addr;
        logic [CNT_W-1:0] cnt;
    } wlk_t;

    wlk_t wlk_d, wlk_q;

    always_comb begin
        wlk_d = wlk_q;
        if (load) begin
            wlk_d.addr = load_addr;
            wlk_d.cnt  = load_cnt;
        end else if (step) begin
            wlk_d.addr = wlk_q.addr + STEP_V;
            wlk_d.cnt  = wlk_q.cnt - ONE_C;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wlk_q <= '0;
        end else begin
            wlk_q <= wlk_d;
        end
    end

    assign addr   = wlk_q.addr;
    assign remain = wlk_q.cnt;
    assign last   = (wlk_q.cnt == ONE_C);

    // R4: an accepted word moves the address by one word and the count by one
    a_r4_step_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr == $past(addr) + STEP_V) && (remain == $past(remain) - ONE_C));

endmodule

// File: rtl/bdm_errstat.sv
module bdm_errstat #(
    parameter int STAT_W  = 32,
    parameter int ERR_BIT = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic              clr,
    input  logic              mask,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    typedef struct packed {
        logic err;
    } est_t;

    est_t est_d, est_q;

    always_comb begin
        est_d = est_q;
        if (set) begin
            est_d.err = 1'b1;
        end else if (clr) begin
            est_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            est_q <= '0;
        end else begin
            est_q <= est_d;
        end
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b == ERR_BIT) begin : g_err
            assign status[b] = est_q.err;
        end else begin : g_rsv
            assign status[b] = 1'b0;
        end
    end

    assign irq = est_q.err & ~mask;

    // R9: the error bit holds until a clear arrives
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ERR_BIT] && !clr) |=> status[ERR_BIT]);

    // R9: a reported error with the mask open raises the interrupt
    a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !mask) |=> (irq || mask));

endmodule

// File: rtl/burst_dma_master.sv
module burst_dma_master
    import bdm_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int CNT_W   = 16,
    parameter int STAT_W  = 32,
    parameter int ERR_BIT = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic              cmd_early,
    input  logic [BUS_W-1:0]  cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              req_n,
    input  logic              grant_n,
    input  logic              ready_n,
    input  logic              abort_n,
    input  logic              buserr_n,
    output logic              dir_rd,
    output logic              addr_strobe,
    output logic              ad_oe,
    output logic [BUS_W-1:0]  ad_out,
    input  logic [BUS_W-1:0]  ad_in,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    output logic              word_ack,
    output logic              done,
    input  logic              irq_mask,
    input  logic              err_clr,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    typedef struct packed {
        bdm_state_e st;
        logic       dir;
        logic       early;
        logic       done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             s_rdy, s_abt;
    logic [BUS_W-1:0] s_data;
    logic             w_load, w_step, w_last;
    logic [BUS_W-1:0] w_addr;
    logic [CNT_W-1:0] w_remain;
    logic             e_set;
    logic             in_data;

    assign in_data = (ctl_q.st == ST_DATA);

    bdm_sampler #(.BUS_W(BUS_W)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .early   (ctl_q.early),
        .in_data (in_data),
        .ready_n (ready_n),
        .abort_n (abort_n),
        .ad_in   (ad_in),
        .rdy     (s_rdy),
        .abt     (s_abt),
        .data    (s_data)
    );

    bdm_walker #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_wlk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (w_load),
        .load_addr (cmd_addr),
        .load_cnt  (cmd_count),
        .step      (w_step),
        .addr      (w_addr),
        .remain    (w_remain),
        .last      (w_last)
    );

    bdm_errstat #(.STAT_W(STAT_W), .ERR_BIT(ERR_BIT)) u_est (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (e_set),
        .clr    (err_clr),
        .mask   (irq_mask),
        .status (status),
        .irq    (irq)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        w_load     = 1'b0;
        w_step     = 1'b0;
        e_set      = 1'b0;
        word_ack   = 1'b0;
        if (!buserr_n) begin
            e_set    = 1'b1;
            ctl_d.st = ST_IDLE;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        w_load      = 1'b1;
                        ctl_d.dir   = cmd_read;
                        ctl_d.early = cmd_early;
                        if (cmd_count == '0) begin
                            ctl_d.done = 1'b1;
                        end else begin
                            ctl_d.st = ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (grant_n) begin
                        ctl_d.st = ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (!grant_n) begin
                        ctl_d.st = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    ctl_d.st = ST_DATA;
                end
                ST_DATA: begin
                    if (s_abt) begin
                        ctl_d.st = ST_HOLD;
                    end else if (s_rdy) begin
                        word_ack = 1'b1;
                        w_step   = 1'b1;
                        if (w_last) begin
                            ctl_d.st   = ST_IDLE;
                            ctl_d.done = 1'b1;
                        end
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, dir: 1'b1, early: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_n       = ~((ctl_q.st == ST_REQ) || (ctl_q.st == ST_ADDR) || (in_data && !w_last));
    assign dir_rd      = ctl_q.dir;
    assign addr_strobe = (ctl_q.st == ST_ADDR);
    assign ad_oe       = addr_strobe || (in_data && !ctl_q.dir);
    assign ad_out      = addr_strobe ? w_addr : wr_data;
    assign rd_data     = s_data;
    assign done        = ctl_q.done;

    // R3: the request never falls while the grant is still held low
    a_r3_req_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(grant_n));

    // R3: the address cycle follows a grant seen while requesting
    a_r3_addr_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> ($past(!grant_n) && $past(!req_n)));

    // R2: direction does not change while the bus is requested
    a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && $past(!req_n)) |-> $stable(dir_rd));

    // R8: a bus error releases the bus in the following cycle
    a_r8_err_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !buserr_n |=> (req_n && !ad_oe && !addr_strobe));

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the count never wraps below zero
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        word_ack |-> (w_remain != '0));

endmodule

// File: tb/burst_dma_master_test.sv
module burst_dma_master_test;

    localparam int BUS_W = 32;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic       rd;
        logic       early;
        logic [7:0] cnt;
        logic [15:0] mask;
        logic [7:0] abort_at;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'd4, 16'hFFFF, 8'hFF},
        '{1'b1, 1'b1, 8'd4, 16'hFFFF, 8'hFF},
        '{1'b0, 1'b1, 8'd5, 16'hACB6, 8'hFF},
        '{1'b0, 1'b0, 8'd3, 16'h5555, 8'hFF},
        '{1'b1, 1'b1, 8'd6, 16'hFFFF, 8'd2},
        '{1'b0, 1'b0, 8'd4, 16'hF3F3, 8'd1},
        '{1'b1, 1'b0, 8'd1, 16'hFFFF, 8'hFF}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n, cmd_valid, cmd_read, cmd_early;
    logic [BUS_W-1:0] cmd_addr, ad_in, wr_data, ad_out, rd_data;
    logic [CNT_W-1:0] cmd_count;
    logic             req_n, grant_n, ready_n, abort_n, buserr_n;
    logic             dir_rd, addr_strobe, ad_oe, word_ack, done;
    logic             irq_mask, err_clr, irq;
    logic [31:0]      status;

    int n_checks = 0;
    int n_fail   = 0;

    burst_dma_master uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_early(cmd_early), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
        .req_n(req_n), .grant_n(grant_n), .ready_n(ready_n), .abort_n(abort_n),
        .buserr_n(buserr_n), .dir_rd(dir_rd), .addr_strobe(addr_strobe),
        .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in), .wr_data(wr_data),
        .rd_data(rd_data), .word_ack(word_ack), .done(done),
        .irq_mask(irq_mask), .err_clr(err_clr), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic step_drive();
        @(posedge clk);
        #1;
    endtask

    task automatic run_xfer(input vec_t v, input logic [31:0] base, output bit ok);
        int left, words, strobes, exp_strobes, j;
        bit in_data, next_in, p_in, p_rdy, p_abt, req_low_prev, exp_done, finished;
        bit r_now, a_now, exp_ack, eff_abt, backoff;
        logic [31:0] p_ad, cur_ad;
        int fails_before;
        fails_before = n_fail;
        left = int'(v.cnt); words = 0; strobes = 0; exp_strobes = 1; j = 0;
        in_data = 0; p_in = 0; p_rdy = 0; p_abt = 0; exp_done = 0; finished = 0;
        backoff = 0; p_ad = '0;
        step_drive();
        cmd_valid = 1'b1; cmd_read = v.rd; cmd_early = v.early;
        cmd_addr = base; cmd_count = CNT_W'(v.cnt);
        step_drive();
        cmd_valid = 1'b0;
        #1;
        chk(dir_rd == v.rd, "R2 direction after command", 32'(dir_rd), 32'(v.rd));
        req_low_prev = !req_n;
        for (int c = 0; c < 300 && !finished; c++) begin
            step_drive();
            grant_n = !req_low_prev;
            r_now   = in_data && v.mask[j % 16];
            a_now   = in_data && (j == int'(v.abort_at));
            ready_n = !r_now;
            abort_n = !a_now;
            cur_ad  = 32'hD000_0000 | 32'(c);
            ad_in   = cur_ad;
            wr_data = 32'hA000_0000 + 32'(words);
            #1;
            exp_ack = in_data && (v.early ? (r_now && !a_now) : (p_in && p_rdy && !p_abt));
            eff_abt = in_data && (v.early ? a_now : (p_in && p_abt));
            chk(word_ack == exp_ack, "R6 word_ack timing", 32'(word_ack), 32'(exp_ack));
            chk(done == exp_done, "R5 done pulse", 32'(done), 32'(exp_done));
            if (in_data)
                chk(req_n == (left == 1), "R5 request in data phase", 32'(req_n), 32'(left == 1));
            if (backoff)
                chk(req_n == 1'b1, "R7 request backs off", 32'(req_n), 32'd1);
            if (exp_ack && v.rd)
                chk(rd_data == (v.early ? cur_ad : p_ad), "R4 read word", rd_data, v.early ? cur_ad : p_ad);
            if (exp_ack && !v.rd)
                chk(ad_oe && ad_out == wr_data, "R4 write word", ad_out, wr_data);
            if (addr_strobe) begin
                strobes++;
                chk(ad_oe && ad_out == base + 32'(4 * words), "R3 R7 address cycle", ad_out, base + 32'(4 * words));
            end
            if (exp_done) finished = 1;
            exp_done = 0;
            backoff  = 0;
            p_in = in_data; p_rdy = r_now; p_abt = a_now; p_ad = cur_ad;
            if (in_data) j++;
            next_in = in_data;
            if (exp_ack) begin
                words++;
                left--;
                if (left == 0) begin
                    next_in  = 0;
                    exp_done = 1;
                end
            end else if (eff_abt) begin
                next_in = 0;
                exp_strobes++;
                backoff = 1;
            end
            if (addr_strobe) next_in = 1;
            in_data = next_in;
            req_low_prev = !req_n;
        end
        chk(words == int'(v.cnt), "R4 words acknowledged", 32'(words), 32'(v.cnt));
        chk(strobes == exp_strobes, "R7 address cycles", 32'(strobes), 32'(exp_strobes));
        chk(finished, "R5 burst finished", 32'(finished), 32'd1);
        grant_n = 1'b1; ready_n = 1'b1; abort_n = 1'b1;
        ok = (n_fail == fails_before);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog expired act=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit ok;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0; cmd_early = 1'b0;
        cmd_addr = '0; cmd_count = '0; grant_n = 1'b1; ready_n = 1'b1;
        abort_n = 1'b1; buserr_n = 1'b1; ad_in = '0; wr_data = '0;
        irq_mask = 1'b0; err_clr = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(req_n == 1'b1 && dir_rd == 1'b1 && ad_oe == 1'b0 && addr_strobe == 1'b0,
            "R1 reset bus outputs", {28'd0, req_n, dir_rd, ad_oe, addr_strobe}, 32'h0000_000C);
        chk(word_ack == 1'b0 && done == 1'b0 && status == 32'd0 && irq == 1'b0,
            "R1 reset status", status, 32'd0);
        rst_n = 1'b1;

        // vector table: bursts over direction, mode, length, ready pattern, abort
        for (int i = 0; i < NV; i++) begin
            run_xfer(VECS[i], 32'h1000_0000 + 32'(i) * 32'h100, ok);
        end

        // R2: zero-length command
        step_drive();
        cmd_valid = 1'b1; cmd_read = 1'b0; cmd_count = '0; cmd_addr = 32'h2000_0000;
        step_drive();
        cmd_valid = 1'b0;
        #1;
        chk(done == 1'b1 && req_n == 1'b1, "R2 zero count done", {30'd0, done, req_n}, 32'd3);
        step_drive();
        #1;
        chk(done == 1'b0 && req_n == 1'b1, "R2 zero count no request", {30'd0, done, req_n}, 32'd1);

        // R8: bus error in the middle of a read burst
        step_drive();
        cmd_valid = 1'b1; cmd_read = 1'b1; cmd_early = 1'b1; cmd_count = 16'd8;
        cmd_addr = 32'h3000_0000;
        step_drive();
        cmd_valid = 1'b0;
        for (int k = 0; k < 20 && !addr_strobe; k++) begin
            step_drive();
            grant_n = req_n;
            #1;
        end
        step_drive();
        #1;
        chk(req_n == 1'b0, "R8 burst running before error", 32'(req_n), 32'd0);
        step_drive();
        buserr_n = 1'b0;
        step_drive();
        buserr_n = 1'b1;
        grant_n  = 1'b1;
        #1;
        chk(req_n == 1'b1 && ad_oe == 1'b0, "R8 bus released", {30'd0, req_n, ad_oe}, 32'd2);
        chk(status == 32'h0200_0000, "R9 error bit 25 set", status, 32'h0200_0000);
        chk(irq == 1'b1, "R9 interrupt raised", 32'(irq), 32'd1);
        repeat (5) step_drive();
        #1;
        chk(req_n == 1'b1 && addr_strobe == 1'b0, "R8 stays idle", 32'(req_n), 32'd1);
        chk(status[25] == 1'b1, "R9 error bit sticky", status, 32'h0200_0000);
        irq_mask = 1'b1;
        #1;
        chk(irq == 1'b0, "R9 masked interrupt", 32'(irq), 32'd0);
        irq_mask = 1'b0;
        #1;
        chk(irq == 1'b1, "R9 unmasked interrupt", 32'(irq), 32'd1);
        step_drive();
        err_clr = 1'b1;
        step_drive();
        err_clr = 1'b0;
        #1;
        chk(status == 32'd0 && irq == 1'b0, "R9 write-one clear", status, 32'd0);

        // R10: a new command after the error
        run_xfer('{1'b0, 1'b1, 8'd3, 16'hFFFF, 8'hFF}, 32'h4000_0000, ok);
        chk(ok, "R10 burst after error", 32'(ok), 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule